// File: doc/BRIEF.md
# Masked Packed Half-to-Single Widening Converter

This block widens up to sixteen packed IEEE binary16 values into packed binary32 values and captures the result in a 512-bit destination register. A two-bit length select sets how many lanes are in use: 4, 8 or 16. Each lane carries a write-enable bit. When masking is on, a single mode flag decides what a masked-off lane receives. In merge mode it keeps the word supplied on the previous-destination input. In zero mode it receives zero.

Because every binary16 value has an exact binary32 form, the conversion needs no rounding. Subnormal inputs are normalized into exact single-precision values. They are never flushed to zero, and no denormal indication is produced. Signaling NaNs are quieted, and a flag reports that this happened. Destination bits above the selected vector length are always cleared.

The register loads only when the input strobe is high. The output valid strobe follows one cycle later.

Top module: `h2s_vec_widen`

## Requirements
- R1: Source lane j is `src[16j+15:16j]` and its result goes to `dst[32j+31:32j]`. A normal input (exponent field 1..30) converts to the same sign, exponent field + 112, and the 10-bit fraction followed by 13 zero bits.
- R2: A signed zero (exponent 0, fraction 0) converts to a single-precision zero with the same sign.
- R3: A subnormal input (exponent 0, fraction nonzero) converts to the exact normalized value. The exponent field is 112 minus the leading-zero count of the 10-bit fraction. The fraction is the input fraction shifted left until its leading one drops out, then followed by 13 zero bits. No flush to zero ever occurs.
- R4: An infinity (exponent 31, fraction 0) converts to exponent 0xFF with a zero fraction and the same sign.
- R5: A NaN (exponent 31, fraction nonzero) converts to exponent 0xFF. Its payload is shifted left by 13, and fraction bit 22 is forced to 1. `qnan_flag` is 1 for a transaction if any lane written with a converted value held a signaling NaN (fraction bit 9 equal to 0).
- R6: With `mask_en` = 0, every lane inside the vector length receives its converted value, whatever `lane_mask` holds.
- R7: With `mask_en` = 1, `zero_mode` = 0 and `lane_mask[j]` = 0, lane j takes `prev_dst[32j+31:32j]`.
- R8: With `mask_en` = 1, `zero_mode` = 1 and `lane_mask[j]` = 0, lane j is written with 0.
- R9: `vlen_sel` 0 selects 4 lanes, 1 selects 8 lanes, and 2 or 3 select 16 lanes. All destination bits at or above 32 × lane count are 0.
- R10: `dst` and `qnan_flag` load only in a cycle where `in_valid` is 1. `out_valid` equals `in_valid` from the previous cycle. Reset clears `dst`, `qnan_flag` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for the destination register |
| src | input | 256 | Packed binary16 source, lane j at bits 16j+15:16j |
| prev_dst | input | 512 | Previous destination, used for merged lanes |
| lane_mask | input | 16 | Per-lane write enable |
| mask_en | input | 1 | 1 applies lane_mask, 0 writes all lanes |
| zero_mode | input | 1 | 1 zeroes masked lanes, 0 merges them |
| vlen_sel | input | 2 | Vector length: 0 = 128, 1 = 256, 2/3 = 512 bits |
| out_valid | output | 1 | High the cycle after a load |
| dst | output | 512 | Registered packed binary32 result |
| qnan_flag | output | 1 | A signaling NaN was quieted in a written lane |

## Verification
Normal values of both signs and across the exponent range show that the rebias and fraction placement are right in every lane position. Subnormals with the leading one at each of the ten fraction positions exercise every leading-zero count. This separates a correct normalization from an off-by-one or a flush. Quiet and signaling NaNs are placed in lanes that are written and in lanes that are masked off, to show that the flag follows only the written lanes. Alternating and sparse masks under merge mode, zero mode and masking off, crossed with all four length codes, tell a lane-selection fault apart from a length-clearing fault.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

    localparam int HALF_W   = 16;
    localparam int SINGLE_W = 32;
    localparam int EXP_REBIAS = 112;

    typedef struct packed {
        logic       sign;
        logic [4:0] exp;
        logic [9:0] frac;
    } half_t;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } single_t;

    typedef enum logic [1:0] {
        HC_ZERO    = 2'd0,
        HC_SUBNORM = 2'd1,
        HC_NORMAL  = 2'd2,
        HC_SPECIAL = 2'd3
    } hclass_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512X = 2'd3
    } vlen_e;

    function automatic hclass_e classify(half_t h);
        if (h.exp == 5'd31)     return HC_SPECIAL;
        else if (h.exp != 5'd0) return HC_NORMAL;
        else if (h.frac == '0)  return HC_ZERO;
        else                    return HC_SUBNORM;
    endfunction

    // count of zero bits above the leading one of a nonzero 10-bit fraction
    function automatic logic [3:0] lead_zeros10(logic [9:0] v);
        logic [3:0] cnt;
        logic       seen;
        cnt  = 4'd0;
        seen = 1'b0;
        for (int i = 9; i >= 0; i--) begin
            if (!seen && v[i]) seen = 1'b1;
            else if (!seen)    cnt  = cnt + 4'd1;
        end
        return cnt;
    endfunction

    function automatic logic [4:0] lanes_for(vlen_e v);
        case (v)
            VL_128:  return 5'd4;
            VL_256:  return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/h2s_lane_cvt.sv
module h2s_lane_cvt
    import h2s_pkg::*;
(
    input  half_t   h_in,
    output single_t s_out,
    output logic    is_snan
);
    hclass_e    cls;
    logic [3:0] lz;
    logic [9:0] norm_frac;

    always_comb begin
        cls       = classify(h_in);
        lz        = lead_zeros10(h_in.frac);
        norm_frac = h_in.frac << (lz + 4'd1);
        s_out.sign = h_in.sign;
        is_snan    = 1'b0;
        case (cls)
            HC_ZERO: begin
                s_out.exp  = 8'd0;
                s_out.frac = '0;
            end
            HC_SUBNORM: begin
                s_out.exp  = 8'(EXP_REBIAS) - {4'd0, lz};
                s_out.frac = {norm_frac, 13'd0};
            end
            HC_NORMAL: begin
                s_out.exp  = {3'd0, h_in.exp} + 8'(EXP_REBIAS);
                s_out.frac = {h_in.frac, 13'd0};
            end
            default: begin
                s_out.exp = 8'hFF;
                if (h_in.frac == '0) begin
                    s_out.frac = '0;
                end else begin
                    s_out.frac = {1'b1, h_in.frac[8:0], 13'd0};
                    is_snan    = ~h_in.frac[9];
                end
            end
        endcase
    end

    // R3: subnormal result must be a nonzero normal in the binary16-subnormal range
    always_comb begin
        if (h_in.exp == 5'd0 && h_in.frac != '0)
            p_sub_norm_r3: assert (s_out.exp >= 8'd103 && s_out.exp <= 8'd112)
                else $error("subnormal exponent out of range");
    end

    // R5: every NaN leaves quiet
    always_comb begin
        if (h_in.exp == 5'd31 && h_in.frac != '0)
            p_nan_quiet_r5: assert (s_out.exp == 8'hFF && s_out.frac[22])
                else $error("NaN not quiet");
    end

endmodule

// File: rtl/h2s_lane_pick.sv
module h2s_lane_pick
    import h2s_pkg::*;
(
    input  single_t     conv,
    input  logic [31:0] prev_word,
    input  logic        in_range,
    input  logic        wr_en,
    input  logic        zero_mode,
    output logic [31:0] word,
    output logic        takes_conv
);
    always_comb begin
        takes_conv = in_range && wr_en;
        if (!in_range)      word = '0;
        else if (wr_en)     word = conv;
        else if (zero_mode) word = '0;
        else                word = prev_word;
    end
endmodule

// File: rtl/h2s_vec_widen.sv
module h2s_vec_widen
    import h2s_pkg::*;
#(
    parameter int MAX_LANES = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [255:0] src,
    input  logic [511:0] prev_dst,
    input  logic [15:0]  lane_mask,
    input  logic         mask_en,
    input  logic         zero_mode,
    input  logic [1:0]   vlen_sel,
    output logic         out_valid,
    output logic [511:0] dst,
    output logic         qnan_flag
);
    localparam int DST_W = MAX_LANES * SINGLE_W;

    logic [4:0]           lane_cnt;
    logic [DST_W-1:0]     next_dst;
    logic [MAX_LANES-1:0] snan_v;
    logic [MAX_LANES-1:0] conv_v;
    logic                 next_flag;

    assign lane_cnt = lanes_for(vlen_e'(vlen_sel));

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        single_t cv;
        logic    sn;

        h2s_lane_cvt u_cvt (
            .h_in   (half_t'(src[j*HALF_W +: HALF_W])),
            .s_out  (cv),
            .is_snan(sn)
        );

        h2s_lane_pick u_pick (
            .conv      (cv),
            .prev_word (prev_dst[j*SINGLE_W +: SINGLE_W]),
            .in_range  (5'(j) < lane_cnt),
            .wr_en     (!mask_en || lane_mask[j]),
            .zero_mode (zero_mode),
            .word      (next_dst[j*SINGLE_W +: SINGLE_W]),
            .takes_conv(conv_v[j])
        );

        assign snan_v[j] = sn;
    end

    assign next_flag = |(snan_v & conv_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            dst       <= '0;
            qnan_flag <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst       <= 512'(next_dst);
                qnan_flag <= next_flag;
            end
        end
    end

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("out_valid missing");
    p_valid_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("out_valid spurious");
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dst) && $stable(qnan_flag)) else $error("dst changed without strobe");
    p_upper_clear_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && vlen_sel == 2'd0 |=> (dst >> 128) == '0) else $error("upper bits not clear");
    p_merge_lane0_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && mask_en && !zero_mode && !lane_mask[0]
        |=> dst[31:0] == $past(prev_dst[31:0])) else $error("merge lane 0");
    p_zero_lane0_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && mask_en && zero_mode && !lane_mask[0]
        |=> dst[31:0] == 32'd0) else $error("zero lane 0");

endmodule

// File: tb/h2s_vec_widen_tb.sv
`timescale 1ns/1ps
module h2s_vec_widen_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] src;
    logic [511:0] prev_dst;
    logic [15:0]  lane_mask;
    logic         mask_en, zero_mode;
    logic [1:0]   vlen_sel;
    logic         out_valid, qnan_flag;
    logic [511:0] dst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    h2s_vec_widen u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .prev_dst(prev_dst),
        .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .vlen_sel(vlen_sel), .out_valid(out_valid), .dst(dst), .qnan_flag(qnan_flag)
    );

    function automatic logic [31:0] ref_cvt(input logic [15:0] h);
        logic [4:0]  e;
        logic [10:0] mm;
        int          ex;
        e = h[14:10];
        if (e == 5'd31) begin
            if (h[9:0] == 0) return {h[15], 8'hFF, 23'd0};
            return {h[15], 8'hFF, 1'b1, h[8:0], 13'd0};
        end
        if (e == 5'd0) begin
            if (h[9:0] == 0) return {h[15], 31'd0};
            mm = {1'b0, h[9:0]};
            ex = 113;
            while (!mm[10]) begin
                mm = mm << 1;
                ex = ex - 1;
            end
            return {h[15], 8'(ex), mm[9:0], 13'd0};
        end
        return {h[15], 8'(int'(e) + 112), h[9:0], 13'd0};
    endfunction

    function automatic int nlanes(input logic [1:0] v);
        return (v == 2'd0) ? 4 : (v == 2'd1) ? 8 : 16;
    endfunction

    logic [511:0] exp_dst;
    logic         exp_flag;

    task automatic model();
        exp_dst  = '0;
        exp_flag = 1'b0;
        for (int j = 0; j < nlanes(vlen_sel); j++) begin
            logic [15:0] h;
            h = src[16*j +: 16];
            if (!mask_en || lane_mask[j]) begin
                exp_dst[32*j +: 32] = ref_cvt(h);
                if (h[14:10] == 5'd31 && h[9:0] != 0 && !h[9]) exp_flag = 1'b1;
            end else if (!zero_mode) begin
                exp_dst[32*j +: 32] = prev_dst[32*j +: 32];
            end
        end
    endtask

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // drive one transaction, check the registered result one edge later
    task automatic run(input string tag);
        model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " dst"}, dst, exp_dst);
        chk({tag, " qnan_flag R5"}, 512'(qnan_flag), 512'(exp_flag));
        chk({tag, " out_valid R10"}, 512'(out_valid), 512'd1);
    endtask

    task automatic setup(input logic [15:0] m, input logic me, input logic zm, input logic [1:0] vl);
        lane_mask = m; mask_en = me; zero_mode = zm; vlen_sel = vl;
        for (int j = 0; j < 16; j++) prev_dst[32*j +: 32] = 32'hA5A50000 + 32'(j);
    endtask

    task automatic t_reset();
        chk("R10 reset dst", dst, '0);
        chk("R10 reset out_valid", 512'(out_valid), '0);
        chk("R10 reset qnan_flag", 512'(qnan_flag), '0);
    endtask

    task automatic t_normals();
        setup(16'h0000, 1'b0, 1'b0, 2'd2);
        for (int j = 0; j < 16; j++)
            src[16*j +: 16] = {j[0], 5'(1 + 2*j), 10'(37*j + 5)};
        src[15:0] = 16'h3C00; src[31:16] = 16'hC000; src[47:32] = 16'h7BFF; src[63:48] = 16'h0400;
        run("R1 normals");
        chk("R1 lane0 1.0", {480'd0, dst[31:0]}, 512'h3F800000);
    endtask

    task automatic t_zero_inf();
        setup(16'h0000, 1'b0, 1'b0, 2'd3);
        for (int j = 0; j < 16; j++)
            src[16*j +: 16] = (j % 4 == 0) ? 16'h0000 : (j % 4 == 1) ? 16'h8000 :
                              (j % 4 == 2) ? 16'h7C00 : 16'hFC00;
        run("R2 R4 zeros and infinities");
        chk("R2 negative zero", {480'd0, dst[63:32]}, 512'h80000000);
        chk("R4 negative inf", {480'd0, dst[127:96]}, 512'hFF800000);
    endtask

    task automatic t_subnormals();
        setup(16'h0000, 1'b0, 1'b0, 2'd2);
        for (int j = 0; j < 16; j++)
            src[16*j +: 16] = {j[1], 5'd0, 10'(10'd1 << (j % 10)) | 10'(j / 10)};
        run("R3 subnormals");
        chk("R3 smallest", {480'd0, dst[31:0]}, 512'h33800000);
    endtask

    task automatic t_nan();
        setup(16'h00FE, 1'b1, 1'b1, 2'd1);
        src = '0;
        src[15:0]   = 16'h7C01;
        src[31:16]  = 16'hFE12;
        src[111:96] = 16'h7D55;
        run("R5 masked signaling NaN");
        chk("R5 lane1 quiet", {480'd0, dst[63:32]}, 512'hFFC24000);
        src[15:0] = 16'h7E00;
        src[111:96] = 16'h7C3F;
        run("R5 written signaling NaN");
        chk("R5 lane6 quieted", {480'd0, dst[223:192]}, 512'h7FC7E000);
    endtask

    task automatic t_masks();
        for (int j = 0; j < 16; j++) src[16*j +: 16] = 16'h3800 + 16'(j * 64);
        setup(16'h5A5A, 1'b1, 1'b0, 2'd2); run("R7 merge alternating");
        setup(16'h0001, 1'b1, 1'b0, 2'd2); run("R7 merge sparse");
        setup(16'h5A5A, 1'b1, 1'b1, 2'd2); run("R8 zero alternating");
        setup(16'h8000, 1'b1, 1'b1, 2'd2); run("R8 zero sparse");
        setup(16'h0000, 1'b0, 1'b1, 2'd2); run("R6 mask off ignores zero lane_mask");
        setup(16'h1234, 1'b0, 1'b0, 2'd1); run("R6 mask off 8 lanes");
    endtask

    task automatic t_vlen();
        for (int j = 0; j < 16; j++) src[16*j +: 16] = 16'hC400 + 16'(j);
        for (int v = 0; v < 4; v++) begin
            setup(16'hFFFF, 1'b0, 1'b0, 2'(v));
            run("R9 length clear");
            chk("R9 upper bits", dst >> (32 * nlanes(2'(v))), '0);
        end
        setup(16'h0F0F, 1'b1, 1'b0, 2'd0); run("R9 merge short length");
    endtask

    task automatic t_hold();
        logic [511:0] keep;
        logic         kflag;
        keep  = dst;
        kflag = qnan_flag;
        src = ~src; setup(16'h0000, 1'b1, 1'b1, 2'd2);
        repeat (3) @(negedge clk);
        chk("R10 hold dst", dst, keep);
        chk("R10 hold flag", 512'(qnan_flag), 512'(kflag));
        chk("R10 out_valid low", 512'(out_valid), '0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; src = '0; prev_dst = '0;
        lane_mask = '0; mask_en = 1'b0; zero_mode = 1'b0; vlen_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normals();
        t_zero_inf();
        t_subnormals();
        t_nan();
        t_masks();
        t_vlen();
        t_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule